// File: doc/BRIEF.md
# Programmable-Priority Interrupt Pending Controller

This block gathers interrupt requests from forty sources and tells the processor which one to serve next. Sources 0 to 7 are external pins. Each pin is synchronized and then watched for transitions, and the edge that counts is chosen per pin. Sources 8 to 39 are internal request lines from on-chip peripherals.

Every source carries a 5-bit priority level written by software. A request latches into a per-source pending bit. The controller then picks the pending source with the highest level, and on a tie the lower-numbered source wins. It presents the winner's index, its level and a valid flag from registers. It also gives a 32-bit map with one bit per level, set when any pending source holds that level. Several sources may share a level, so one handler can serve a whole group.

Software uses a small register port. It writes the levels and the pin edge selects, reads back all registers, and clears pending bits by writing ones.

Top module: `pic40`

## Requirements
- R1: After reset, every level register, every pending bit and the edge-select register read as zero, and `irq_valid`, `irq_id`, `irq_level` and `level_pending` are zero.
- R2: While no source is pending, `irq_valid`, `irq_id`, `irq_level` and `level_pending` are all zero one cycle later.
- R3: A high `int_req[j]` at a rising clock edge sets the pending bit of source 8+j at that edge.
- R4: External pin p passes two synchronizing flops. An edge seen between the second flop and a third history flop sets the pending bit of source p. The edge that counts comes from bits [2p+1:2p] of the edge-select register at address 40, where bit 2p enables rising edges and bit 2p+1 enables falling edges.
- R5: With the pin's edge-select code at 00, transitions on that pin set nothing. With code 01, only rising edges count. With code 10, only falling edges count. With code 11, both edges count.
- R6: The level of source i is written at address i (0..39) from `bus_wdata[4:0]` and reads back zero-extended.
- R7: One cycle after the pending set changes, `irq_id` and `irq_level` name the pending source with the highest level, with 31 the highest and 0 the lowest, and `irq_valid` is 1.
- R8: Among pending sources that share the top level, the lowest source index wins.
- R9: Writing address 41 clears the pending bits of sources 0..31 wherever `bus_wdata` has a one. Writing address 42 does the same for sources 32..39 using `bus_wdata[7:0]`. Zero bits leave their pending bits unchanged. Reads of 41 and 42 return the pending bits in the same positions.
- R10: When a request sets a pending bit in the same cycle as a write clears it, the bit stays set.
- R11: Bit L of `level_pending` is 1 one cycle after some pending source has level L, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 8 | External interrupt pins, asynchronous |
| int_req | input | 32 | Internal request lines, sources 8..39 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| irq_valid | output | 1 | Some source is pending |
| irq_id | output | 6 | Index of the winning source |
| irq_level | output | 5 | Level of the winning source |
| level_pending | output | 32 | One bit per level holding a pending source |

## Verification
The hardest case to reach from the ports is a request and its clear landing on the same clock edge. The stimulus handles this by driving an internal request line high in the same half-cycle that it starts the write-one-to-clear access, so both fall on one edge. The bench then reads the pending word back to confirm the bit survived. Pin edges are harder to time because of the three flops between pin and pending bit. The stimulus therefore walks one pin through all four edge-select codes, clearing pending state between steps, so that each edge direction is seen to be either ignored or caught.

// File: rtl/pic40.sv
module pic40 #(
  parameter int N_EXT = 8,
  parameter int N_INT = 32,
  parameter int LW    = 5,
  parameter int DW    = 32,
  parameter int AW    = 6,
  localparam int NS   = N_EXT + N_INT,
  localparam int IDW  = $clog2(NS),
  localparam int NL   = 1 << LW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_EXT-1:0] ext_pin,
  input  logic [N_INT-1:0] int_req,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           irq_valid,
  output logic [IDW-1:0] irq_id,
  output logic [LW-1:0]  irq_level,
  output logic [NL-1:0]  level_pending
);
  localparam int A_CFG = NS;
  localparam int A_P0  = NS + 1;
  localparam int A_P1  = NS + 2;

  logic [LW-1:0]        lvl [NS];
  logic [2*N_EXT-1:0]   ecfg;
  logic [NS-1:0]        pend, set_vec, clr_vec;
  logic [N_EXT-1:0]     s1, s2, s3, rise, fall, edge_hit;
  logic [2*DW-1:0]      pend_w;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= ext_pin; s2 <= s1; s3 <= s2;
    end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  for (genvar p = 0; p < N_EXT; p++) begin : g_edge
    assign edge_hit[p] = (ecfg[2*p] & rise[p]) | (ecfg[2*p+1] & fall[p]);
  end

  assign set_vec = {int_req, edge_hit};

  always_comb begin
    clr_vec = '0;
    if (bus_we && bus_addr == AW'(A_P0))
      clr_vec = NS'({{DW{1'b0}}, bus_wdata});
    else if (bus_we && bus_addr == AW'(A_P1))
      clr_vec = NS'({bus_wdata, {DW{1'b0}}});
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_vec) | set_vec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ecfg <= '0;
      for (int i = 0; i < NS; i++) lvl[i] <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(A_CFG)) ecfg <= bus_wdata[2*N_EXT-1:0];
      for (int i = 0; i < NS; i++)
        if (bus_addr == AW'(i)) lvl[i] <= bus_wdata[LW-1:0];
    end

  assign pend_w = (2*DW)'(pend);

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NS; i++)
      if (bus_addr == AW'(i)) bus_rdata = DW'(lvl[i]);
    if (bus_addr == AW'(A_CFG)) bus_rdata = DW'(ecfg);
    if (bus_addr == AW'(A_P0))  bus_rdata = pend_w[DW-1:0];
    if (bus_addr == AW'(A_P1))  bus_rdata = pend_w[2*DW-1:DW];
  end

  logic           w_hit;
  logic [IDW-1:0] w_id;
  logic [LW-1:0]  w_lvl;
  logic [NL-1:0]  w_map;

  always_comb begin
    w_hit = 1'b0;
    w_id  = '0;
    w_lvl = '0;
    w_map = '0;
    for (int i = 0; i < NS; i++)
      if (pend[i]) begin
        w_map[lvl[i]] = 1'b1;
        if (!w_hit || lvl[i] > w_lvl) begin
          w_hit = 1'b1;
          w_id  = IDW'(i);
          w_lvl = lvl[i];
        end
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      irq_valid <= 1'b0; irq_id <= '0; irq_level <= '0; level_pending <= '0;
    end else begin
      irq_valid <= w_hit; irq_id <= w_id; irq_level <= w_lvl; level_pending <= w_map;
    end
endmodule

// File: rtl/pic40_chk.sv
module pic40_chk #(
  parameter int NS  = 40,
  parameter int LW  = 5,
  parameter int IDW = 6,
  parameter int NL  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NS-1:0]  pend,
  input logic [NS-1:0]  set_vec,
  input logic           irq_valid,
  input logic [IDW-1:0] irq_id,
  input logic [LW-1:0]  irq_level,
  input logic [NL-1:0]  level_pending
);
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (pend & $past(set_vec)) == $past(set_vec));

  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n || !live)
    (pend & ~$past(pend) & ~$past(set_vec)) == '0);

  a_r7_valid_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n || !live)
    irq_valid == ($past(pend) != '0));

  a_r7_winner_was_pending: assert property (@(posedge clk) disable iff (!rst_n || !live)
    irq_valid |-> ((($past(pend) >> irq_id) & NS'(1)) != '0));

  a_r11_winner_level_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> level_pending[irq_level]);

  a_r2_idle_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_id == '0 && irq_level == '0 && level_pending == '0));
endmodule

bind pic40 pic40_chk #(.NS(NS), .LW(LW), .IDW(IDW), .NL(NL)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend), .set_vec(set_vec),
  .irq_valid(irq_valid), .irq_id(irq_id), .irq_level(irq_level),
  .level_pending(level_pending)
);

// File: tb/pic40_tb.sv
module pic40_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ext_pin = '0;
  logic [31:0] int_req = '0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_valid;
  logic [5:0]  irq_id;
  logic [4:0]  irq_level;
  logic [31:0] level_pending;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic40 u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .int_req(int_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_valid(irq_valid), .irq_id(irq_id),
    .irq_level(irq_level), .level_pending(level_pending)
  );

  typedef struct {
    string       tag;
    logic        vld;
    int          id;
    int          lv;
    logic [31:0] map;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int          lm [40];
  logic [39:0] pm = '0;

  task automatic chk(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic push_expect(string tag);
    item_t it;
    it.tag = tag; it.vld = 0; it.id = 0; it.lv = 0; it.map = '0;
    for (int i = 0; i < 40; i++)
      if (pm[i]) begin
        it.map[lm[i]] = 1'b1;
        if (!it.vld || lm[i] > it.lv) begin
          it.vld = 1; it.id = i; it.lv = lm[i];
        end
      end
    q.push_back(it);
  endtask

  task automatic settle(string tag);
    repeat (5) @(negedge clk);
    push_expect(tag);
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_we = 1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_wdata = '0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    bus_addr = 6'(a);
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse_int(int j);
    int_req[j] = 1'b1;
    @(negedge clk);
    int_req[j] = 1'b0;
    pm[8+j] = 1'b1;
  endtask

  task automatic clear_all();
    wr(41, '1); wr(42, '1);
    pm = '0;
  endtask

  always begin
    @(negedge clk);
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk({it.tag, " valid"}, irq_valid, it.vld);
      chk({it.tag, " id"}, irq_id, it.id);
      chk({it.tag, " level"}, irq_level, it.lv);
      chk({it.tag, " level map"}, level_pending, it.map);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 40; i++) lm[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    push_expect("R1 reset outputs");
    repeat (2) @(negedge clk);
    rd(5, 0, "R1 level reg after reset");
    rd(40, 0, "R1 edge select after reset");
    rd(41, 0, "R1 pending low after reset");
    rd(42, 0, "R1 pending high after reset");

    // R6 level write and readback
    wr(18, 7);  lm[18] = 7;
    wr(11, 7);  lm[11] = 7;
    wr(30, 20); lm[30] = 20;
    wr(39, 31); lm[39] = 31;
    wr(2, 25);  lm[2] = 25;
    rd(18, 7, "R6 level readback src18");
    rd(39, 31, "R6 level readback src39");

    // R3 internal request, R7 winner
    pulse_int(10);
    settle("R3 R7 single internal src18");
    // R8 tie goes to the lower index
    pulse_int(3);
    settle("R8 tie src11 vs src18");
    pulse_int(22);
    settle("R7 higher level src30");
    rd(41, 32'h4004_0800, "R9 pending low readback");
    // R9 write-one-to-clear, zeros leave bits alone
    wr(41, 32'h0);
    settle("R9 zero write no effect");
    wr(41, 32'h4000_0000); pm[30] = 0;
    settle("R9 clear src30");
    // R9 high word
    pulse_int(31);
    settle("R7 top level src39");
    rd(42, 32'h80, "R9 pending high readback");
    wr(42, 32'h80); pm[39] = 0;
    settle("R9 clear src39 via high word");

    // R10 set wins over same-cycle clear
    int_req[3] = 1'b1;
    wr(41, 32'h0000_0800);
    int_req[3] = 1'b0;
    settle("R10 set beats clear");
    rd(41, 32'h0004_0800, "R10 src11 still pending");

    // R4 R5 pin 2 through all edge-select codes
    clear_all();
    settle("R2 idle after clear");
    ext_pin[2] = 1'b1;
    settle("R5 code 00 rising ignored");
    ext_pin[2] = 1'b0;
    settle("R5 code 00 falling ignored");
    wr(40, 32'h10);
    ext_pin[2] = 1'b1; pm[2] = 1;
    settle("R4 code 01 rising caught");
    wr(41, 32'h4); pm[2] = 0;
    ext_pin[2] = 1'b0;
    settle("R5 code 01 falling ignored");
    wr(40, 32'h20);
    ext_pin[2] = 1'b1;
    settle("R5 code 10 rising ignored");
    ext_pin[2] = 1'b0; pm[2] = 1;
    settle("R5 code 10 falling caught");
    rd(40, 32'h20, "R4 edge select readback");
    wr(41, 32'h4); pm[2] = 0;
    wr(40, 32'h30);
    ext_pin[2] = 1'b1; pm[2] = 1;
    settle("R5 code 11 rising caught");
    wr(41, 32'h4); pm[2] = 0;
    ext_pin[2] = 1'b0; pm[2] = 1;
    settle("R5 code 11 falling caught");

    // R11 level map with several levels pending
    pulse_int(10);
    pulse_int(22);
    settle("R11 three levels pending");
    clear_all();
    settle("R2 idle at end");

    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule